// File: doc/BRIEF.md
# Triplicated Pulse Counter with Voting

This block counts pulses from eight current-to-frequency converter channels in a radiation environment. Each channel's pulse train arrives on three redundant lines. Every line is synchronised on its own and edge-detected on its own. The three rising-edge indications are then majority voted, so one faulty line cannot add counts or lose them. All state that must survive a single-event upset is held in three copies. This covers the per-channel counters, the dead-channel timers, the sticky fault flags, the readout pointer and the output registers. A bitwise voter reads the copies, and every copy is reloaded each cycle from the voted value, so an upset copy is corrected on the next clock.

A small bias current is always injected into each converter, so a healthy channel never goes quiet. A per-channel timer raises a dead flag when no voted edge arrives within a programmable number of cycles. Readout is sequential. Each acquisition strobe puts the next channel's voted count on the data bus, and a 4-bit control code names that channel. Two identical copies of both buses are driven, each from its own triplicated register.

Top module: `tmr_pulse_counter`

## Requirements
- R1: After reset every count is zero. Both data buses read 0, both control buses read 0, and all dead, mismatch and sequencing-fault flags are 0.
- R2: A channel's count increases by exactly one for each voted rising edge. A line held high for many cycles counts once.
- R3: Each channel counts only its own pulses. Pulsing one channel leaves the others' counts unchanged.
- R4: A pulse counts when at least two of the three lines of a channel rise together. A pulse seen on only one line does not count.
- R5: When the three synchronised lines of a channel do not all agree, that channel's mismatch bit is set. The bit stays set until reset.
- R6: The dead flag of a channel is 1 once `dead_limit` cycles pass with no voted edge on that channel, and 0 while fewer cycles have passed.
- R7: A dead flag returns to 0 on the cycle after the channel's next voted edge, provided `dead_limit` is nonzero.
- R8: On each cycle with `acq_strobe` high, the data bus loads the count of the channel at the readout pointer. The control code becomes {1'b1, channel[2:0]}, where bit 3 is the valid marker and bits 2:0 are the channel index. The pointer then steps 0,1,…,7 and wraps to 0.
- R9: The secondary data and control buses always equal the primary ones.
- R10: Without `acq_strobe` the data and control buses hold their values, even while pulses are being counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_a | input | 8 | First redundant pulse line, one bit per channel |
| line_b | input | 8 | Second redundant pulse line |
| line_c | input | 8 | Third redundant pulse line |
| dead_limit | input | 16 | Cycles without a pulse before a channel is flagged dead |
| acq_strobe | input | 1 | Present the next channel's count |
| data_p | output | 16 | Primary data bus |
| data_s | output | 16 | Secondary data bus |
| ctrl_p | output | 4 | Primary control code {valid, channel} |
| ctrl_s | output | 4 | Secondary control code |
| dead_flag | output | 8 | Per-channel dead indication |
| mismatch | output | 8 | Per-channel sticky line-disagreement flag |
| seq_mismatch | output | 1 | Sticky flag for copy disagreement in pointer or output registers |

## Verification
The bench drives a channel with only two of its three lines, and then with only one. A design that ORs the lines instead of voting them would count the single-line pulse, and one that ANDs them would miss the two-line pulse. A long high level is sent to catch level-sensitive counting, which would add many counts instead of one. The bench then reads all eight channels and then reads further, past the wrap. This exposes a pointer that skips a channel, does not wrap, or labels the wrong channel on the control code. The dead flag is probed well before and well after the limit, and then again right after a single pulse. A flag that never clears, or a timer that restarts on the wrong channel, shows up there.

// File: rtl/tpc_pkg.sv
// Package: shared sizes for the triplicated pulse counter.
// Assumes a 4-bit control code of one valid bit plus a 3-bit channel index.
package tpc_pkg;
    localparam int CTRL_W  = 4;
    localparam int CHIDX_W = CTRL_W - 1;
    localparam int NCOPY   = 3;
endpackage

// File: rtl/tpc_voter.sv
// Module: bitwise two-of-three majority voter.
// Also reports whether any copy differs from the voted result.
// Assumes all three inputs share one width.
module tpc_voter #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] c,
    output logic [W-1:0] y,
    output logic         diff
);
    // Majority per bit, plus the disagreement indication.
    always_comb begin
        y    = (a & b) | (a & c) | (b & c);
        diff = (a != y) || (b != y) || (c != y);
    end
endmodule

// File: rtl/tpc_tmr_reg.sv
// Module: triplicated register with voted output and scrubbing.
// All three copies load the same next value each cycle. A corrupted copy is
// therefore rewritten from the voted value one clock later.
// Assumes the next value d is computed from the voted output q.
module tpc_tmr_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic         err
);
    import tpc_pkg::*;

    logic [W-1:0] copy_q [NCOPY];

    for (genvar k = 0; k < NCOPY; k++) begin : g_copy
        // One storage copy, cleared by reset.
        always_ff @(posedge clk) begin
            if (!rst_n) copy_q[k] <= '0;
            else        copy_q[k] <= d;
        end
    end

    tpc_voter #(.W(W)) u_vote (
        .a(copy_q[0]), .b(copy_q[1]), .c(copy_q[2]),
        .y(q), .diff(err)
    );
endmodule

// File: rtl/tpc_line_sync.sv
// Module: two-flop synchroniser with rising-edge detect for one pulse line.
// Assumes pulses stay high and low for at least one clock each.
module tpc_line_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic lev,
    output logic rise
);
    logic meta_q, sync_q, prev_q;

    // Two synchroniser stages, then one history stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= raw;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    // Present the synchronised level and its rising edge.
    always_comb begin
        lev  = sync_q;
        rise = sync_q & ~prev_q;
    end
endmodule

// File: rtl/tpc_channel.sv
// Module: one converter channel. Votes the three edge indications, counts
// voted edges, times the gap since the last edge, and keeps a sticky flag.
// The flag is set when the lines disagree or a stored copy is corrupted.
// Assumes lev/rise come from three independent synchronisers.
module tpc_channel #(
    parameter int CNT_W = 16,
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       lev,
    input  logic [2:0]       rise,
    input  logic [TMR_W-1:0] dead_limit,
    output logic [CNT_W-1:0] count,
    output logic             vedge,
    output logic             dead,
    output logic             mism
);
    logic             edge_diff;
    logic             line_diff;
    logic [CNT_W-1:0] cnt_d;
    logic [TMR_W-1:0] gap_d, gap_q;
    logic             cnt_err, gap_err, mm_err;
    logic             mm_d;

    tpc_voter #(.W(1)) u_edge_vote (
        .a(rise[0]), .b(rise[1]), .c(rise[2]),
        .y(vedge), .diff(edge_diff)
    );

    // Next count, gap timer and sticky flag, all from voted state.
    always_comb begin
        line_diff = (lev != 3'b000) && (lev != 3'b111);
        cnt_d     = count + {{(CNT_W-1){1'b0}}, vedge};
        if (vedge)              gap_d = '0;
        else if (gap_q == '1)   gap_d = gap_q;
        else                    gap_d = gap_q + 1'b1;
        mm_d = mism | line_diff | edge_diff | cnt_err | gap_err | mm_err;
    end

    tpc_tmr_reg #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .d(cnt_d), .q(count), .err(cnt_err)
    );

    tpc_tmr_reg #(.W(TMR_W)) u_gap (
        .clk(clk), .rst_n(rst_n), .d(gap_d), .q(gap_q), .err(gap_err)
    );

    tpc_tmr_reg #(.W(1)) u_mm (
        .clk(clk), .rst_n(rst_n), .d(mm_d), .q(mism), .err(mm_err)
    );

    // Dead once the gap timer has reached the programmed limit.
    always_comb dead = (gap_q >= dead_limit);
endmodule

// File: rtl/tmr_pulse_counter.sv
// Module: top of the triplicated pulse counter. Takes three redundant lines
// per channel and keeps voted counts and dead-channel flags. It presents one
// channel per acquisition strobe on two identical data and control buses.
// Assumes NCH <= 8 so the channel index fits the 3-bit control field.
module tmr_pulse_counter #(
    parameter int NCH   = 8,
    parameter int CNT_W = 16,
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCH-1:0]   line_a,
    input  logic [NCH-1:0]   line_b,
    input  logic [NCH-1:0]   line_c,
    input  logic [TMR_W-1:0] dead_limit,
    input  logic             acq_strobe,
    output logic [CNT_W-1:0] data_p,
    output logic [CNT_W-1:0] data_s,
    output logic [3:0]       ctrl_p,
    output logic [3:0]       ctrl_s,
    output logic [NCH-1:0]   dead_flag,
    output logic [NCH-1:0]   mismatch,
    output logic             seq_mismatch
);
    import tpc_pkg::*;

    localparam int LANES  = 2;
    localparam int LANE_W = CTRL_W + CNT_W;

    logic [2:0]         raw_l  [NCH];
    logic [2:0]         lev_l  [NCH];
    logic [2:0]         rise_l [NCH];
    logic [CNT_W-1:0]   cnt    [NCH];
    logic [NCH-1:0]     chan_edge;

    logic [CHIDX_W-1:0] ptr_d, ptr_q;
    logic               ptr_err;
    logic [LANE_W-1:0]  lane_d;
    logic [LANE_W-1:0]  lane_q   [LANES];
    logic [LANES-1:0]   lane_err;
    logic               sq_d, sq_err;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        // Gather the three redundant copies of this channel's line.
        always_comb raw_l[i] = {line_c[i], line_b[i], line_a[i]};

        for (genvar k = 0; k < NCOPY; k++) begin : g_line
            tpc_line_sync u_sync (
                .clk(clk), .rst_n(rst_n), .raw(raw_l[i][k]),
                .lev(lev_l[i][k]), .rise(rise_l[i][k])
            );
        end

        tpc_channel #(.CNT_W(CNT_W), .TMR_W(TMR_W)) u_chan (
            .clk(clk), .rst_n(rst_n), .lev(lev_l[i]), .rise(rise_l[i]),
            .dead_limit(dead_limit), .count(cnt[i]), .vedge(chan_edge[i]),
            .dead(dead_flag[i]), .mism(mismatch[i])
        );
    end

    // Advance the readout pointer on a strobe, wrapping after the last channel.
    always_comb begin
        if (!acq_strobe)                        ptr_d = ptr_q;
        else if (ptr_q == CHIDX_W'(NCH - 1))    ptr_d = '0;
        else                                    ptr_d = ptr_q + 1'b1;
    end

    tpc_tmr_reg #(.W(CHIDX_W)) u_ptr (
        .clk(clk), .rst_n(rst_n), .d(ptr_d), .q(ptr_q), .err(ptr_err)
    );

    // Next output word: the selected count with its valid-marked channel code.
    always_comb begin
        lane_d = lane_q[0];
        if (acq_strobe) lane_d = {1'b1, ptr_q, cnt[ptr_q]};
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        tpc_tmr_reg #(.W(LANE_W)) u_out (
            .clk(clk), .rst_n(rst_n), .d(lane_d), .q(lane_q[l]),
            .err(lane_err[l])
        );
    end

    // Sticky record of any copy disagreement in the sequencing registers.
    always_comb sq_d = seq_mismatch | ptr_err | (|lane_err) | sq_err;

    tpc_tmr_reg #(.W(1)) u_sq (
        .clk(clk), .rst_n(rst_n), .d(sq_d), .q(seq_mismatch), .err(sq_err)
    );

    // Drive the two bus copies from their own registers.
    always_comb begin
        {ctrl_p, data_p} = lane_q[0];
        {ctrl_s, data_s} = lane_q[1];
    end
endmodule

// File: rtl/tpc_checker.sv
// Module: property checker for the triplicated pulse counter.
// Observes ports plus the voted edge of each channel.
module tpc_checker #(
    parameter int NCH   = 8,
    parameter int CNT_W = 16,
    parameter int TMR_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             acq_strobe,
    input logic [CNT_W-1:0] data_p,
    input logic [CNT_W-1:0] data_s,
    input logic [3:0]       ctrl_p,
    input logic [3:0]       ctrl_s,
    input logic [NCH-1:0]   mismatch,
    input logic [NCH-1:0]   dead_flag,
    input logic [NCH-1:0]   chan_edge,
    input logic [TMR_W-1:0] dead_limit
);
    AST_BUS_TWIN: assert property (@(posedge clk) disable iff (!rst_n)
        (data_p == data_s) && (ctrl_p == ctrl_s)); // R9

    AST_MISMATCH_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((mismatch & $past(mismatch)) == $past(mismatch))); // R5

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !acq_strobe |=> ($stable(data_p) && $stable(ctrl_p))); // R10

    AST_STROBE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        acq_strobe |=> ctrl_p[3]); // R8

    AST_CHAN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (acq_strobe && ctrl_p[3]) |=>
        (ctrl_p[2:0] == (($past(ctrl_p[2:0]) == 3'(NCH - 1)) ? 3'd0
                         : $past(ctrl_p[2:0]) + 3'd1))); // R8

    for (genvar i = 0; i < NCH; i++) begin : g_dead
        AST_DEAD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            (chan_edge[i] && (dead_limit != '0)) |=> !dead_flag[i]); // R7
    end
endmodule

bind tmr_pulse_counter tpc_checker #(.NCH(NCH), .CNT_W(CNT_W), .TMR_W(TMR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .acq_strobe(acq_strobe),
    .data_p(data_p), .data_s(data_s), .ctrl_p(ctrl_p), .ctrl_s(ctrl_s),
    .mismatch(mismatch), .dead_flag(dead_flag), .chan_edge(chan_edge),
    .dead_limit(dead_limit)
);

// File: tb/tb_tmr_pulse_counter.sv
module tb_tmr_pulse_counter;
    localparam int CLK_PERIOD = 10;
    localparam int NCH   = 8;
    localparam int CNT_W = 16;
    localparam int TMR_W = 16;
    localparam int LIMIT = 40;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NCH-1:0]   line_a = '0, line_b = '0, line_c = '0;
    logic [TMR_W-1:0] dead_limit = TMR_W'(LIMIT);
    logic             acq_strobe = 1'b0;
    logic [CNT_W-1:0] data_p, data_s;
    logic [3:0]       ctrl_p, ctrl_s;
    logic [NCH-1:0]   dead_flag, mismatch;
    logic             seq_mismatch;

    int total = 0;
    int bad   = 0;
    int exp_cnt [NCH];
    int exp_ptr = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr_pulse_counter #(.NCH(NCH), .CNT_W(CNT_W), .TMR_W(TMR_W)) dut (
        .clk(clk), .rst_n(rst_n), .line_a(line_a), .line_b(line_b),
        .line_c(line_c), .dead_limit(dead_limit), .acq_strobe(acq_strobe),
        .data_p(data_p), .data_s(data_s), .ctrl_p(ctrl_p), .ctrl_s(ctrl_s),
        .dead_flag(dead_flag), .mismatch(mismatch), .seq_mismatch(seq_mismatch)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Pulse the channels in chmask on the lines in lines (bit0=a, bit1=b, bit2=c).
    task automatic pulse(input logic [NCH-1:0] chmask, input logic [2:0] lines, input int hi);
        @(negedge clk);
        if (lines[0]) line_a = chmask;
        if (lines[1]) line_b = chmask;
        if (lines[2]) line_c = chmask;
        idle(hi);
        line_a = '0; line_b = '0; line_c = '0;
        idle(4);
        if ($countones(lines) >= 2)
            for (int i = 0; i < NCH; i++) if (chmask[i]) exp_cnt[i]++;
    endtask

    // One strobe, then check both buses against the expected channel and count.
    task automatic strobe_chk(input string req);
        @(negedge clk);
        acq_strobe = 1'b1;
        @(negedge clk);
        acq_strobe = 1'b0;
        chk({req, " ctrl"}, {28'd0, ctrl_p}, {28'd0, 1'b1, 3'(exp_ptr)});
        chk({req, " data"}, {16'd0, data_p}, 32'(exp_cnt[exp_ptr] & 16'hFFFF));
        chk("R9 twin", {ctrl_s, data_s}, {ctrl_p, data_p});
        exp_ptr = (exp_ptr + 1) % NCH;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        idle(3);
        rst_n = 1'b1;
        idle(1);
        chk("R1 data", {16'd0, data_p}, 0);
        chk("R1 ctrl", {28'd0, ctrl_p}, 0);
        chk("R1 flags", {mismatch, dead_flag, 7'd0, seq_mismatch}, 0);
    endtask

    task automatic t_count;
        pulse(8'h01, 3'b111, 2);
        pulse(8'h01, 3'b111, 12);   // R2 long high counts once
        pulse(8'h05, 3'b111, 2);
        pulse(8'h80, 3'b111, 3);    // R3 separate channel
        for (int i = 0; i < NCH; i++) strobe_chk("R2 R3 R8");
        chk("R5 clean lines", {24'd0, mismatch}, 0);
    endtask

    task automatic t_hold;
        logic [19:0] snap;
        snap = {ctrl_p, data_p};
        pulse(8'hFF, 3'b111, 2);
        idle(10);
        chk("R10 hold", {12'd0, ctrl_p, data_p}, {12'd0, snap});
    endtask

    task automatic t_vote;
        pulse(8'h20, 3'b011, 2);    // two of three: counts
        pulse(8'h40, 3'b100, 2);    // one of three: ignored
        chk("R5 set", {24'd0, mismatch}, 32'h60);
        pulse(8'hFF, 3'b111, 2);
        chk("R5 sticky", {24'd0, mismatch}, 32'h60);
        for (int i = 0; i < NCH + 3; i++) strobe_chk("R4 R8 wrap");
    endtask

    task automatic t_dead;
        pulse(8'hFF, 3'b111, 2);
        idle(LIMIT / 2);
        chk("R6 before limit", {24'd0, dead_flag}, 0);
        idle(LIMIT);
        chk("R6 after limit", {24'd0, dead_flag}, 32'hFF);
        pulse(8'h08, 3'b111, 2);
        chk("R7 cleared", {24'd0, dead_flag}, 32'hF7);
        chk("R1 seq fault", {31'd0, seq_mismatch}, 0);
    endtask

    initial begin
        for (int i = 0; i < NCH; i++) exp_cnt[i] = 0;
        t_reset();
        t_count();
        t_hold();
        t_vote();
        t_dead();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        bad++;
        total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule